// File: doc/BRIEF.md
# Memory Data/Address Tag Control

This block keeps the two tag bits that travel with the memory-data register and the memory-address register. It also produces the write enables for those two registers. Each instruction presents a decoded functional destination and two instruction bits that carry new tag values. The destination kind decides which tags reload and which register is written. An early-start read loads the address tag at once. It holds its data tag in a staging slot until the read commits, and drops it if the read is cancelled.

An earlier memory write may still be deciding whether it traps. While it is, a destination that would disturb either register is held with a pipeline freeze. The freeze lasts until the write resolves. A clean resolution lets the held destination finish in that same cycle. A trapping resolution kills it, so both registers and both tags keep their old values for the trap handler. A parameter selects the guard. The conservative variant freezes on every functional destination. The narrow variant freezes only on destinations that touch the two registers or their tags.

Top module: `mdtag_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it, tag_status is 2'b00 and freeze, dest_kill, data_we and addr_we are 0 when no destination is presented.
- R2: dest_kind 1 (data register) asserts data_we in the same cycle, and after the clock edge the data tag (tag_status bit 1) equals ir_tag_data; the address tag is unchanged.
- R3: dest_kind 2 (address register) asserts addr_we only, and after the edge the address tag (tag_status bit 0) equals ir_tag_addr; the data tag is unchanged.
- R4: dest_kind 3 (start-read) asserts addr_we, and after the edge both tags load, data tag from ir_tag_data and address tag from ir_tag_addr.
- R5: dest_kind 5 (start-write) asserts addr_we and loads the address tag from ir_tag_addr; the data tag is kept.
- R6: dest_kind 6 (data-register start-write) asserts data_we and loads both tags.
- R7: While wr_pending is 1 and wr_resolve is 0, a valid destination of kind 1 to 6 raises freeze, write enables stay 0, and tag_status stays unchanged for as long as it is held.
- R8: When wr_resolve rises with wr_trap 0 while a destination is frozen, freeze drops and the destination completes in that same cycle.
- R9: When wr_resolve rises with wr_trap 1 while a destination is frozen, dest_kill is 1, no write enable is raised, and tag_status stays unchanged.
- R10: With the default conservative setting, dest_kind 7 (other functional destination) also freezes while a write is pending; dest_kind 0 (register-file destination) never freezes.
- R11: dest_kind 4 (early start-read) asserts addr_we and loads the address tag at once; the data tag loads from the staged ir_tag_data only when rd_commit is pulsed, and data_we is asserted in that commit cycle.
- R12: After rd_cancel, a staged early-read data tag is discarded: a later rd_commit raises no data_we and leaves the data tag unchanged.
- R13: A destination presented with abort 1 raises no write enable, stages nothing, and changes no tag.
- R14: tag_status reports the data tag in bit 1 and the address tag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dest_valid | input | 1 | A destination is presented this cycle |
| dest_kind | input | 3 | Decoded destination kind, codes 0 to 7 |
| ir_tag_data | input | 1 | Instruction bit that gives the new data tag |
| ir_tag_addr | input | 1 | Instruction bit that gives the new address tag |
| abort | input | 1 | Current instruction is trapped; its destination is dropped |
| wr_pending | input | 1 | An earlier memory write has not yet resolved its trap outcome |
| wr_resolve | input | 1 | The pending write resolves this cycle |
| wr_trap | input | 1 | The resolving write traps |
| rd_commit | input | 1 | The staged early read commits |
| rd_cancel | input | 1 | The staged early read is cancelled |
| data_we | output | 1 | Write enable for the memory-data register |
| addr_we | output | 1 | Write enable for the memory-address register |
| freeze | output | 1 | Hold the pipeline; the destination is waiting |
| dest_kill | output | 1 | The held destination is inhibited by a trap |
| tag_status | output | 2 | {data tag, address tag} |

## Verification
The write enables, freeze and dest_kill are combinational functions of the inputs of the current cycle. The bench drives inputs just after a falling edge and samples these outputs a moment later, before the next rising edge. Tag values take one register stage, so each tag check is made at the falling edge after the rising edge that consumed the destination. This applies both while a freeze is held and after it is released. The staged early-read tag takes one edge to stage and one more edge after the commit cycle to appear on tag_status, and the bench samples at both points.

// File: rtl/mdtag_pkg.sv
// Shared types for the memory tag control block.
// Assumes a 3-bit decoded destination kind supplied by the instruction decoder.
package mdtag_pkg;

    typedef enum logic [2:0] {
        DK_REGFILE       = 3'd0,
        DK_DATA          = 3'd1,
        DK_ADDR          = 3'd2,
        DK_START_RD      = 3'd3,
        DK_START_RD_EARLY= 3'd4,
        DK_START_WR      = 3'd5,
        DK_DATA_START_WR = 3'd6,
        DK_OTHER_FUNC    = 3'd7
    } dest_kind_e;

    typedef struct packed {
        logic functional;  // destination is a functional (non register-file) one
        logic wr_data;     // writes the memory-data register
        logic wr_addr;     // writes the memory-address register
        logic ld_dtag;     // reloads the data tag now
        logic ld_atag;     // reloads the address tag now
        logic stage_dtag;  // stages the data tag until the read commits
    } dest_effect_t;

    localparam int KIND_W = 3;

endpackage

// File: rtl/mdtag_decode.sv
// Destination decoder: maps a destination kind to the register and tag
// effects it has. Purely combinational; assumes kind_i is stable in-cycle.
module mdtag_decode
    import mdtag_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output dest_effect_t      eff_o
);

    // Table of effects per destination kind.
    always_comb begin
        eff_o = '0;
        case (dest_kind_e'(kind_i))
            DK_REGFILE: begin
                eff_o = '0;
            end
            DK_DATA: begin
                eff_o.functional = 1'b1;
                eff_o.wr_data    = 1'b1;
                eff_o.ld_dtag    = 1'b1;
            end
            DK_ADDR: begin
                eff_o.functional = 1'b1;
                eff_o.wr_addr    = 1'b1;
                eff_o.ld_atag    = 1'b1;
            end
            DK_START_RD: begin
                eff_o.functional = 1'b1;
                eff_o.wr_addr    = 1'b1;
                eff_o.ld_dtag    = 1'b1;
                eff_o.ld_atag    = 1'b1;
            end
            DK_START_RD_EARLY: begin
                eff_o.functional = 1'b1;
                eff_o.wr_addr    = 1'b1;
                eff_o.ld_atag    = 1'b1;
                eff_o.stage_dtag = 1'b1;
            end
            DK_START_WR: begin
                eff_o.functional = 1'b1;
                eff_o.wr_addr    = 1'b1;
                eff_o.ld_atag    = 1'b1;
            end
            DK_DATA_START_WR: begin
                eff_o.functional = 1'b1;
                eff_o.wr_data    = 1'b1;
                eff_o.ld_dtag    = 1'b1;
                eff_o.ld_atag    = 1'b1;
            end
            DK_OTHER_FUNC: begin
                eff_o.functional = 1'b1;
            end
            default: begin
                eff_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/mdtag_hazard.sv
// Write-in-progress guard: holds a destination while an earlier memory write
// has not resolved its trap outcome, then lets it complete or kills it.
// Assumes the pipeline keeps the destination presented while freeze is high.
module mdtag_hazard
    import mdtag_pkg::*;
#(
    parameter bit CONSERVATIVE_FREEZE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dest_valid_i,
    input  dest_effect_t eff_i,
    input  logic         abort_i,
    input  logic         wr_pending_i,
    input  logic         wr_resolve_i,
    input  logic         wr_trap_i,
    output logic         go_o,
    output logic         freeze_o,
    output logic         kill_o
);

    logic touches;
    logic guarded;
    logic live;
    logic unresolved;
    logic trapped;

    // Whether the destination disturbs either register or tag.
    always_comb begin
        touches = eff_i.wr_data | eff_i.wr_addr | eff_i.ld_dtag |
                  eff_i.ld_atag | eff_i.stage_dtag;
    end

    // The parameter picks which destinations are held while a write is open.
    generate
        if (CONSERVATIVE_FREEZE) begin : g_guard_all_func
            always_comb guarded = eff_i.functional;
        end else begin : g_guard_tagged
            always_comb guarded = touches;
        end
    endgenerate

    // Resolution state of the earlier write and the outcome for this cycle.
    always_comb begin
        live       = dest_valid_i & ~abort_i;
        unresolved = wr_pending_i & ~wr_resolve_i;
        trapped    = wr_pending_i & wr_resolve_i & wr_trap_i;
        freeze_o   = live & guarded & unresolved;
        kill_o     = live & guarded & trapped;
        go_o       = live & ~freeze_o & ~kill_o;
    end

    // R10: a register-file destination is never held by a pending write.
    assert_regfile_no_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_i.functional) |-> !freeze_o);

    // R7: an open write with a touching destination always holds it.
    assert_touch_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_valid_i && !abort_i && touches && wr_pending_i && !wr_resolve_i) |-> freeze_o);

endmodule

// File: rtl/mdtag_tags.sv
// Tag storage: the data and address tag bits and the staging slot used by
// early-start reads. Tags change only on the edge that ends a granted cycle.
// Assumes go_i is already cleared for frozen, killed or aborted cycles.
module mdtag_tags
    import mdtag_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  dest_effect_t eff_i,
    input  logic         new_dtag_i,
    input  logic         new_atag_i,
    input  logic         rd_commit_i,
    input  logic         rd_cancel_i,
    output logic         commit_we_o,
    output logic         data_tag_o,
    output logic         addr_tag_o
);

    logic stage_valid;
    logic stage_tag;
    logic load_d;
    logic load_a;
    logic load_s;
    logic commit_apply;

    // Granted loads and the commit of a staged early-read tag.
    always_comb begin
        load_d       = go_i & eff_i.ld_dtag;
        load_a       = go_i & eff_i.ld_atag;
        load_s       = go_i & eff_i.stage_dtag;
        commit_apply = rd_commit_i & stage_valid & ~rd_cancel_i;
        commit_we_o  = commit_apply;
    end

    // Address tag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_tag_o <= 1'b0;
        end else if (load_a) begin
            addr_tag_o <= new_atag_i;
        end
    end

    // Data tag register; a direct load is newer than a staged value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_tag_o <= 1'b0;
        end else if (load_d) begin
            data_tag_o <= new_dtag_i;
        end else if (commit_apply) begin
            data_tag_o <= stage_tag;
        end
    end

    // Staging slot for the data tag of an early-start read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_valid <= 1'b0;
            stage_tag   <= 1'b0;
        end else if (load_s) begin
            stage_valid <= 1'b1;
            stage_tag   <= new_dtag_i;
        end else if (load_d || rd_cancel_i || commit_apply) begin
            stage_valid <= 1'b0;
        end
    end

    // R3, R5: an address-only load leaves the data tag alone.
    assert_addr_only_keeps_dtag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a && !load_d && !commit_apply) |=> (data_tag_o == $past(data_tag_o)));

    // R11: staging a read tag does not touch the data tag on that edge.
    assert_stage_defers_dtag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && !commit_apply) |=> $stable(data_tag_o));

    // R12: a cancel leaves nothing staged for the next commit.
    assert_cancel_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cancel_i && !load_s) |=> !stage_valid);

endmodule

// File: rtl/mdtag_ctrl.sv
// Top of the memory tag control block: decodes the destination, applies the
// write-in-progress guard, and drives register enables and tag status.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module mdtag_ctrl
    import mdtag_pkg::*;
#(
    parameter bit CONSERVATIVE_FREEZE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dest_valid,
    input  logic [2:0] dest_kind,
    input  logic       ir_tag_data,
    input  logic       ir_tag_addr,
    input  logic       abort,
    input  logic       wr_pending,
    input  logic       wr_resolve,
    input  logic       wr_trap,
    input  logic       rd_commit,
    input  logic       rd_cancel,
    output logic       data_we,
    output logic       addr_we,
    output logic       freeze,
    output logic       dest_kill,
    output logic [1:0] tag_status
);

    dest_effect_t eff;
    logic         go;
    logic         commit_we;
    logic         data_tag;
    logic         addr_tag;

    mdtag_decode u_decode (
        .kind_i (dest_kind),
        .eff_o  (eff)
    );

    mdtag_hazard #(
        .CONSERVATIVE_FREEZE (CONSERVATIVE_FREEZE)
    ) u_hazard (
        .clk          (clk),
        .rst_n        (rst_n),
        .dest_valid_i (dest_valid),
        .eff_i        (eff),
        .abort_i      (abort),
        .wr_pending_i (wr_pending),
        .wr_resolve_i (wr_resolve),
        .wr_trap_i    (wr_trap),
        .go_o         (go),
        .freeze_o     (freeze),
        .kill_o       (dest_kill)
    );

    mdtag_tags u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .eff_i       (eff),
        .new_dtag_i  (ir_tag_data),
        .new_atag_i  (ir_tag_addr),
        .rd_commit_i (rd_commit),
        .rd_cancel_i (rd_cancel),
        .commit_we_o (commit_we),
        .data_tag_o  (data_tag),
        .addr_tag_o  (addr_tag)
    );

    // Register enables and the status word.
    always_comb begin
        data_we    = (go & eff.wr_data) | commit_we;
        addr_we    = go & eff.wr_addr;
        tag_status = {data_tag, addr_tag};
    end

    // R7: a held destination writes neither register.
    assert_freeze_blocks_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !rd_commit) |-> (!data_we && !addr_we));

    // R7: tags hold while the destination is frozen.
    assert_freeze_holds_tags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !rd_commit) |=> $stable(tag_status));

    // R9: a killed destination leaves both tags as they were.
    assert_kill_holds_tags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_kill && !rd_commit) |=> $stable(tag_status));

    // R9: freeze and kill are never raised together.
    assert_kill_not_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(freeze && dest_kill));

    // R13: an aborted destination raises no address write.
    assert_abort_no_addr_we_R13: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !addr_we);

endmodule

// File: tb/sim_mdtag_ctrl.sv
// Directed bench for the memory tag control block.
module sim_mdtag_ctrl;

    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dest_valid;
    logic [2:0] dest_kind;
    logic       ir_tag_data;
    logic       ir_tag_addr;
    logic       abort;
    logic       wr_pending;
    logic       wr_resolve;
    logic       wr_trap;
    logic       rd_commit;
    logic       rd_cancel;
    logic       data_we;
    logic       addr_we;
    logic       freeze;
    logic       dest_kill;
    logic [1:0] tag_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    mdtag_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dest_valid  (dest_valid),
        .dest_kind   (dest_kind),
        .ir_tag_data (ir_tag_data),
        .ir_tag_addr (ir_tag_addr),
        .abort       (abort),
        .wr_pending  (wr_pending),
        .wr_resolve  (wr_resolve),
        .wr_trap     (wr_trap),
        .rd_commit   (rd_commit),
        .rd_cancel   (rd_cancel),
        .data_we     (data_we),
        .addr_we     (addr_we),
        .freeze      (freeze),
        .dest_kill   (dest_kill),
        .tag_status  (tag_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG_CYCLES);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        checks = checks + 1;
        if (actual != expected) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic idle();
        dest_valid = 0; dest_kind = 0; ir_tag_data = 0; ir_tag_addr = 0;
        abort = 0; wr_pending = 0; wr_resolve = 0; wr_trap = 0;
        rd_commit = 0; rd_cancel = 0;
    endtask

    // Present a destination just after a falling edge and let outputs settle.
    task automatic present(input logic [2:0] kind, input logic bd, input logic ba);
        dest_valid = 1; dest_kind = kind; ir_tag_data = bd; ir_tag_addr = ba;
        #1;
    endtask

    // Finish the cycle: rising edge, then back to a falling edge with idle inputs.
    task automatic next_cycle();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 tag_status in reset", tag_status, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 tag_status after reset", tag_status, 0);
        chk("R1 freeze", freeze, 0);
        chk("R1 dest_kill", dest_kill, 0);
        chk("R1 enables", {data_we, addr_we}, 0);
    endtask

    task automatic t_data_dest();
        present(3'd1, 1'b1, 1'b1);
        chk("R2 data_we", data_we, 1);
        chk("R2 addr_we", addr_we, 0);
        next_cycle();
        chk("R2 data tag set, address tag kept", tag_status, 2'b10);
        chk("R14 data tag in bit 1", tag_status[1], 1);
    endtask

    task automatic t_addr_dest();
        present(3'd2, 1'b0, 1'b1);
        chk("R3 enables", {data_we, addr_we}, 2'b01);
        next_cycle();
        chk("R3 address tag set, data tag kept", tag_status, 2'b11);
        chk("R14 address tag in bit 0", tag_status[0], 1);
    endtask

    task automatic t_start_write();
        present(3'd5, 1'b0, 1'b0);
        chk("R5 enables", {data_we, addr_we}, 2'b01);
        next_cycle();
        chk("R5 data tag kept", tag_status, 2'b10);
    endtask

    task automatic t_start_read();
        present(3'd3, 1'b0, 1'b1);
        chk("R4 enables", {data_we, addr_we}, 2'b01);
        next_cycle();
        chk("R4 both tags load", tag_status, 2'b01);
    endtask

    task automatic t_data_start_write();
        present(3'd6, 1'b1, 1'b0);
        chk("R6 data_we", data_we, 1);
        next_cycle();
        chk("R6 both tags load", tag_status, 2'b10);
    endtask

    task automatic t_freeze_release();
        wr_pending = 1;
        present(3'd1, 1'b0, 1'b1);
        for (int i = 0; i < 2; i++) begin
            chk("R7 freeze held", freeze, 1);
            chk("R7 no enables while frozen", {data_we, addr_we}, 0);
            @(negedge clk); #1;
            chk("R7 tags stable while frozen", tag_status, 2'b10);
        end
        wr_resolve = 1; wr_trap = 0; #1;
        chk("R8 freeze drops on clean resolve", freeze, 0);
        chk("R8 data_we on clean resolve", data_we, 1);
        chk("R8 no kill on clean resolve", dest_kill, 0);
        next_cycle();
        chk("R8 data tag updated after release", tag_status, 2'b00);
    endtask

    task automatic t_freeze_trap();
        wr_pending = 1;
        present(3'd3, 1'b1, 1'b1);
        chk("R7 start-read frozen", freeze, 1);
        @(negedge clk);
        wr_resolve = 1; wr_trap = 1; #1;
        chk("R9 dest_kill", dest_kill, 1);
        chk("R9 freeze drops", freeze, 0);
        chk("R9 no enables", {data_we, addr_we}, 0);
        next_cycle();
        chk("R9 tags unchanged", tag_status, 2'b00);
    endtask

    task automatic t_conservative();
        wr_pending = 1;
        present(3'd7, 1'b1, 1'b1);
        chk("R10 other functional destination freezes", freeze, 1);
        dest_kind = 3'd0; #1;
        chk("R10 register-file destination not frozen", freeze, 0);
        next_cycle();
        chk("R10 tags unchanged", tag_status, 2'b00);
    endtask

    task automatic t_early_commit();
        present(3'd4, 1'b1, 1'b1);
        chk("R11 early read enables", {data_we, addr_we}, 2'b01);
        next_cycle();
        chk("R11 only address tag loaded", tag_status, 2'b01);
        rd_commit = 1; #1;
        chk("R11 data_we on commit", data_we, 1);
        chk("R11 addr_we on commit", addr_we, 0);
        next_cycle();
        chk("R11 data tag after commit", tag_status, 2'b11);
    endtask

    task automatic t_early_cancel();
        present(3'd4, 1'b0, 1'b0);
        next_cycle();
        chk("R12 address tag loaded", tag_status, 2'b10);
        rd_cancel = 1; #1;
        next_cycle();
        rd_commit = 1; #1;
        chk("R12 no data_we after cancel", data_we, 0);
        next_cycle();
        chk("R12 data tag unchanged", tag_status, 2'b10);
    endtask

    task automatic t_abort();
        abort = 1;
        present(3'd1, 1'b0, 1'b1);
        chk("R13 no data_we when aborted", data_we, 0);
        next_cycle();
        chk("R13 tags unchanged", tag_status, 2'b10);
        abort = 1;
        present(3'd4, 1'b0, 1'b1);
        chk("R13 no addr_we on aborted early read", addr_we, 0);
        next_cycle();
        rd_commit = 1; #1;
        chk("R13 nothing staged by aborted read", data_we, 0);
        next_cycle();
        chk("R13 tags unchanged after commit", tag_status, 2'b10);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_data_dest();
        t_addr_dest();
        t_start_write();
        t_start_read();
        t_data_start_write();
        t_freeze_release();
        t_freeze_trap();
        t_conservative();
        t_early_commit();
        t_early_cancel();
        t_abort();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule